// File: doc/BRIEF.md
# Switch Frame Forwarding Decision

This block makes the per-frame forwarding choice for one device in an Ethernet switch fabric built from up to 32 cooperating devices. For each received frame it gets the destination MAC address, the outcome of the address table search and the arrival port. The search outcome is a hit or a miss, the owning device and port on a hit, and the entry's CPU flag. From these and a small set of configuration inputs it produces a forwarding vector and a to-CPU indication. The vector has one bit per (device, port) pair, and bit index = device * PORTS + port.

Known unicast frames go straight to their recorded device and port. Unknown unicast frames are flooded to the ports enabled in the flood mask. Multicast and broadcast frames go to the management CPU when one is present, and are flooded otherwise. With intervention mode on, a known unicast entry whose flag is set is handed to the CPU. The arrival port is always removed from the vector. Requests arrive over a valid/ready handshake. Each decision comes out of a register and is held until the consumer takes it.

Top module: `fwd_decide`

## Requirements
- R1: A unicast frame (DA bit 40 clear) that hits in the table, when not intercepted under R5, yields a vector with exactly bit dev*PORTS+port set and the to-CPU output low.
- R2: A unicast frame that misses yields the flood mask as its vector and the to-CPU output low.
- R3: A frame with DA bit 40 set (the least significant bit of the first octet) is multicast, and the all-ones broadcast address counts as multicast. With the CPU-present input high, such a frame yields to-CPU high and an all-zero vector, whatever the hit result.
- R4: With the CPU-present input low, a multicast frame yields the flood mask as its vector and to-CPU low.
- R5: With intervention mode on, a unicast hit whose entry flag is set yields to-CPU high and an all-zero vector. With intervention mode off, and on a miss, the flag has no effect.
- R6: Bit local_dev*PORTS+src_port is clear in every vector. A known unicast whose target is the arrival port yields an all-zero vector.
- R7: A request is accepted on a rising edge where req_valid and req_ready are both high, with req_ready = !dec_valid || dec_ready. Its decision appears with dec_valid high after that same edge, and not before.
- R8: While dec_valid is high and dec_ready is low, the decision outputs stay unchanged and req_ready stays low.
- R9: After reset, dec_valid, dec_to_cpu and the vector are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_da | input | 48 | Destination MAC, first octet in bits 47:40 |
| req_hit | input | 1 | Destination found in table |
| req_dev | input | DW | Owning device on a hit |
| req_port | input | PW | Owning port on a hit |
| req_cpu_flag | input | 1 | Entry flag forcing CPU handling |
| req_src_port | input | PW | Local arrival port |
| cfg_local_dev | input | DW | This device's number |
| cfg_cpu_present | input | 1 | A management CPU exists |
| cfg_intervene | input | 1 | Intervention mode enable |
| cfg_flood_mask | input | NUM_DEV*PORTS | Ports receiving unknown traffic |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes decision |
| dec_vec | output | NUM_DEV*PORTS | Forwarding vector |
| dec_to_cpu | output | 1 | Frame goes to the CPU |

## Verification
The bench sends a broadcast as well as an ordinary group address. A design that tested every bit of the first octet, or only the all-ones case, would forward one of the two in hardware. It sends a known unicast whose target is the arrival port, which an echo-unaware design would send back out. It sets the entry flag with intervention off and on a miss, where a design that over-trusts the flag would hand the frame to the CPU. Finally it stalls the consumer while a new request is waiting: a design that overwrote the held decision, or accepted during the stall, would show the second result too early.

// File: rtl/fwd_decide.sv
`timescale 1ns/1ps
module fwd_decide #(
  parameter int NUM_DEV = 32,
  parameter int PORTS   = 4,
  localparam int DW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int VW = NUM_DEV * PORTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [47:0]   req_da,
  input  logic          req_hit,
  input  logic [DW-1:0] req_dev,
  input  logic [PW-1:0] req_port,
  input  logic          req_cpu_flag,
  input  logic [PW-1:0] req_src_port,
  input  logic [DW-1:0] cfg_local_dev,
  input  logic          cfg_cpu_present,
  input  logic          cfg_intervene,
  input  logic [VW-1:0] cfg_flood_mask,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic [VW-1:0] dec_vec,
  output logic          dec_to_cpu
);

  logic          mcast, intercept, cpu_n, flood_n, acc;
  logic [VW-1:0] arr_bit, tgt_bit, vec_n;

  assign mcast     = req_da[40];
  assign intercept = req_hit & ~mcast & cfg_intervene & req_cpu_flag;
  assign cpu_n     = (mcast & cfg_cpu_present) | intercept;
  assign flood_n   = mcast | ~req_hit;

  assign arr_bit = VW'(1) << (int'(cfg_local_dev) * PORTS + int'(req_src_port));
  assign tgt_bit = VW'(1) << (int'(req_dev) * PORTS + int'(req_port));

  assign vec_n = cpu_n ? '0 : ((flood_n ? cfg_flood_mask : tgt_bit) & ~arr_bit);

  assign req_ready = ~dec_valid | dec_ready;
  assign acc       = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_vec    <= '0;
      dec_to_cpu <= 1'b0;
    end else if (acc) begin
      dec_valid  <= 1'b1;
      dec_vec    <= vec_n;
      dec_to_cpu <= cpu_n;
    end else if (dec_ready) begin
      dec_valid  <= 1'b0;
    end
  end

  // R7: accepted request shows up after the accepting edge
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> dec_valid);

  // R8: stalled decision does not move
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_vec) && $stable(dec_to_cpu));

  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |-> !req_ready);

  // R6: arrival port never echoed
  a_r6_no_echo: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (dec_vec & $past(arr_bit)) == '0);

  // R3: multicast with CPU present goes only to CPU
  a_r3_mcast_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_da[40] && cfg_cpu_present |=> dec_to_cpu && dec_vec == '0);

  // R1: known unicast forwarded to at most one port
  a_r1_single: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_hit && !req_da[40] && !(cfg_intervene && req_cpu_flag)
    |=> !dec_to_cpu && $onehot0(dec_vec));

  // R2: unknown unicast never to CPU
  a_r2_flood: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_hit && !req_da[40] |=> !dec_to_cpu);

endmodule

// File: tb/fwd_decide_tb.sv
`timescale 1ns/1ps
module fwd_decide_tb;
  localparam int ND = 32, NP = 4, VW = ND * NP, LOC = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_hit = 0, req_cpu_flag = 0;
  logic [47:0] req_da = '0;
  logic [4:0] req_dev = '0, cfg_local_dev = 5'(LOC);
  logic [1:0] req_port = '0, req_src_port = '0;
  logic cfg_cpu_present = 1, cfg_intervene = 0;
  logic [VW-1:0] cfg_flood_mask = {4{32'hA5C3_0F96}};
  logic dec_valid, dec_ready = 1, dec_to_cpu;
  logic [VW-1:0] dec_vec;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  fwd_decide u_dut (.clk, .rst_n, .req_valid, .req_ready, .req_da, .req_hit,
    .req_dev, .req_port, .req_cpu_flag, .req_src_port, .cfg_local_dev,
    .cfg_cpu_present, .cfg_intervene, .cfg_flood_mask, .dec_valid, .dec_ready,
    .dec_vec, .dec_to_cpu);

  task automatic chk(string r, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] bitv(int d, int p);
    return VW'(1) << (d * NP + p);
  endfunction

  function automatic logic [VW-1:0] flood(int src);
    return cfg_flood_mask & ~bitv(LOC, src);
  endfunction

  task automatic send(logic [47:0] da, logic hit, int dev, int port, logic flag, int src);
    @(negedge clk);
    req_da = da; req_hit = hit; req_dev = 5'(dev); req_port = 2'(port);
    req_cpu_flag = flag; req_src_port = 2'(src); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R9 valid", VW'(dec_valid), '0);
    chk("R9 vec", dec_vec, '0);
    chk("R9 cpu", VW'(dec_to_cpu), '0);
  endtask

  task automatic t_known;
    send(48'h0012_3456_789A, 1, 9, 2, 0, 1);
    chk("R1 vec", dec_vec, bitv(9, 2));
    chk("R1 cpu", VW'(dec_to_cpu), '0);
    chk("R7 valid", VW'(dec_valid), 1);
  endtask

  task automatic t_unknown;
    send(48'h0200_0000_0001, 0, 0, 0, 0, 3);
    chk("R2 vec", dec_vec, flood(3));
    chk("R2 cpu", VW'(dec_to_cpu), '0);
    chk("R6 flood no echo", dec_vec & bitv(LOC, 3), '0);
  endtask

  task automatic t_mcast_cpu;
    send(48'h0100_5E00_0001, 1, 3, 1, 0, 0);
    chk("R3 mcast cpu", VW'(dec_to_cpu), 1);
    chk("R3 mcast vec", dec_vec, '0);
    send(48'hFFFF_FFFF_FFFF, 0, 0, 0, 0, 2);
    chk("R3 bcast cpu", VW'(dec_to_cpu), 1);
    chk("R3 bcast vec", dec_vec, '0);
  endtask

  task automatic t_mcast_nocpu;
    cfg_cpu_present = 0;
    send(48'h3300_0000_0001, 0, 0, 0, 0, 0);
    chk("R4 vec", dec_vec, flood(0));
    chk("R4 cpu", VW'(dec_to_cpu), '0);
    cfg_cpu_present = 1;
  endtask

  task automatic t_intervene;
    send(48'h0000_1111_2222, 1, 7, 3, 1, 0);
    chk("R5 flag ignored off", dec_vec, bitv(7, 3));
    cfg_intervene = 1;
    send(48'h0000_1111_2222, 1, 7, 3, 1, 0);
    chk("R5 cpu", VW'(dec_to_cpu), 1);
    chk("R5 vec", dec_vec, '0);
    send(48'h0000_1111_2222, 0, 7, 3, 1, 1);
    chk("R5 flag ignored miss", dec_vec, flood(1));
    chk("R5 miss cpu", VW'(dec_to_cpu), '0);
    cfg_intervene = 0;
  endtask

  task automatic t_echo;
    send(48'h0000_AAAA_BBBB, 1, LOC, 2, 0, 2);
    chk("R6 echo vec", dec_vec, '0);
    send(48'h0000_AAAA_BBBB, 1, LOC, 1, 0, 2);
    chk("R6 local other", dec_vec, bitv(LOC, 1));
  endtask

  task automatic t_stall;
    @(negedge clk);
    chk("R7 idle", VW'(dec_valid), '0);
    dec_ready = 0;
    send(48'h0000_0000_0010, 1, 20, 0, 0, 0);
    chk("R7 first", dec_vec, bitv(20, 0));
    req_da = 48'h0000_0000_0020; req_hit = 1; req_dev = 5'd21; req_port = 2'd3;
    req_valid = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 held vec", dec_vec, bitv(20, 0));
      chk("R8 ready low", VW'(req_ready), '0);
    end
    dec_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R8 next vec", dec_vec, bitv(21, 3));
    chk("R8 next valid", VW'(dec_valid), 1);
    @(negedge clk);
    chk("R7 drained", VW'(dec_valid), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_known;
    t_unknown;
    t_mcast_cpu;
    t_mcast_nocpu;
    t_intervene;
    t_echo;
    t_stall;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule